// File: doc/BRIEF.md
# Latching BCD to Seven-Segment Decoder

This block takes one decimal digit as a 4-bit 8421 code and holds it in an internal register. It turns the held value into seven active-high segment drives for one display position. The register is loaded on each rising clock edge while the active-low load control is low, and it keeps its value while that control is high. As a result, the display shows the stored digit and not the live input. Codes above nine give a dark readout.

Three controls change what is shown without touching the stored digit. Lamp test lights every segment. Blank darkens every segment and can be toggled freely to dim the display by pulse modulation. Ripple-blank-in darkens a stored zero. The block raises ripple-blank-out whenever it suppresses such a zero. A row of decoders can therefore hide leading zeros: each position's out feeds the ripple-blank-in of the next less significant position. Trailing zeros are hidden the same way with the chain running in the other direction.

The digit input has no valid/ready handshake and applies no back-pressure. A digit is taken on every clock while the load control is low. The producer must hold the input steady for as long as it wants it captured.

Top module: `bcd7_latch_decoder`

## Requirements
- R1: When `load_n` is low at a rising clock edge, the register captures `digit_in`, and the segments reflect the new value from that edge on. Reset clears the register to 0.
- R2: When `load_n` is high at a rising clock edge, the register keeps its value. The segments ignore any change on `digit_in`.
- R3: With no override active, stored codes 0 to 9 light the following segments, where `seg[0]` is a and `seg[6]` is g. Written as hex of `seg[6:0]`: 0=3F, 1=06, 2=5B, 3=4F, 4=66, 5=6D, 6=7D (a lit), 7=07, 8=7F, 9=6F (d lit).
- R4: With no override active, stored codes 10 to 15 give `seg` = 00.
- R5: When `lamp_test` is high, `seg` = 7F whatever the stored code, `blank` or `rb_in`.
- R6: When `blank` is high and `lamp_test` is low, `seg` = 00.
- R7: `rb_out` is high exactly when `rb_in` is high and the stored code is 0. This holds whatever the state of `lamp_test` and `blank`. When `rb_in` is high, the stored code is 0 and both `lamp_test` and `blank` are low, `seg` = 00.
- R8: `lamp_test` and `blank`, however toggled, leave the stored code unchanged. Once they drop, the earlier digit pattern returns.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| digit_in | input | 4 | 8421 code of the digit to load |
| load_n | input | 1 | Low: load `digit_in` each clock; high: hold |
| lamp_test | input | 1 | High: all segments on |
| blank | input | 1 | High: all segments off (below lamp test) |
| rb_in | input | 1 | High: suppress a stored zero |
| seg | output | 7 | Segment drives, bit 0 = a ... bit 6 = g, active high |
| rb_out | output | 1 | High when a zero was suppressed by `rb_in` |

## Verification
Some rules are checked on every cycle: the lamp-test and blank overrides and their priority, the dark readout for codes above nine, the meaning of ripple-blank-out, and holding the register while the load control is high. Other behaviour can only be shown by the bench's scenarios. These are the exact glyph for each digit, the one-edge load latency, and the return of the old digit once a long run of blank or lamp-test pulses ends. The bench also shows that `rb_in` leaves a non-zero digit alone.

// File: rtl/bcd7_pkg.sv
package bcd7_pkg;
  localparam int SEG_N = 7;
  typedef logic [SEG_N-1:0] seg_t;

  // Which source drives the segment outputs, highest priority first.
  typedef enum logic [1:0] {
    SHOW_LAMP   = 2'd0,
    SHOW_DARK   = 2'd1,
    SHOW_RIPPLE = 2'd2,
    SHOW_DIGIT  = 2'd3
  } show_t;

  localparam seg_t SEG_ALL_ON  = '1;
  localparam seg_t SEG_ALL_OFF = '0;
endpackage

// File: rtl/bcd7_hold_reg.sv
module bcd7_hold_reg #(
  parameter int DIGIT_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_n,
  input  logic [DIGIT_W-1:0] d,
  output logic [DIGIT_W-1:0] q
);
  // Load while load_n is low, keep the value otherwise.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (!load_n) begin
      q <= d;
    end
  end
endmodule

// File: rtl/bcd7_glyph_rom.sv
module bcd7_glyph_rom
  import bcd7_pkg::*;
#(
  parameter int DIGIT_W = 4
) (
  input  logic [DIGIT_W-1:0] code,
  output seg_t               glyph,
  output logic               legal
);
  // Bit 0 = segment a ... bit 6 = segment g.
  always_comb begin
    legal = 1'b1;
    case (code)
      DIGIT_W'(0): glyph = 7'h3F;
      DIGIT_W'(1): glyph = 7'h06;
      DIGIT_W'(2): glyph = 7'h5B;
      DIGIT_W'(3): glyph = 7'h4F;
      DIGIT_W'(4): glyph = 7'h66;
      DIGIT_W'(5): glyph = 7'h6D;
      DIGIT_W'(6): glyph = 7'h7D;
      DIGIT_W'(7): glyph = 7'h07;
      DIGIT_W'(8): glyph = 7'h7F;
      DIGIT_W'(9): glyph = 7'h6F;
      default: begin
        glyph = SEG_ALL_OFF;
        legal = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/bcd7_blank_arb.sv
module bcd7_blank_arb
  import bcd7_pkg::*;
(
  input  logic  lamp_test,
  input  logic  blank,
  input  logic  rb_in,
  input  logic  is_zero,
  input  logic  legal,
  output show_t show,
  output logic  rb_out
);
  // Zero suppression is reported whether or not a higher override wins.
  assign rb_out = rb_in & is_zero;

  always_comb begin
    if (lamp_test)       show = SHOW_LAMP;
    else if (blank)      show = SHOW_DARK;
    else if (!legal)     show = SHOW_DARK;
    else if (rb_out)     show = SHOW_RIPPLE;
    else                 show = SHOW_DIGIT;
  end
endmodule

// File: rtl/bcd7_latch_decoder.sv
module bcd7_latch_decoder
  import bcd7_pkg::*;
#(
  parameter int DIGIT_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DIGIT_W-1:0] digit_in,
  input  logic               load_n,
  input  logic               lamp_test,
  input  logic               blank,
  input  logic               rb_in,
  output logic [SEG_N-1:0]   seg,
  output logic               rb_out
);
  logic [DIGIT_W-1:0] held_q;
  seg_t               glyph;
  logic               legal;
  show_t              show;

  bcd7_hold_reg #(.DIGIT_W(DIGIT_W)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .load_n (load_n),
    .d      (digit_in),
    .q      (held_q)
  );

  bcd7_glyph_rom #(.DIGIT_W(DIGIT_W)) u_rom (
    .code  (held_q),
    .glyph (glyph),
    .legal (legal)
  );

  bcd7_blank_arb u_arb (
    .lamp_test (lamp_test),
    .blank     (blank),
    .rb_in     (rb_in),
    .is_zero   (held_q == '0),
    .legal     (legal),
    .show      (show),
    .rb_out    (rb_out)
  );

  // One output mux per segment.
  for (genvar s = 0; s < SEG_N; s++) begin : g_seg
    always_comb begin
      case (show)
        SHOW_LAMP:  seg[s] = 1'b1;
        SHOW_DIGIT: seg[s] = glyph[s];
        default:    seg[s] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/bcd7_latch_decoder_chk.sv
module bcd7_latch_decoder_chk #(
  parameter int DIGIT_W = 4,
  parameter int SEG_N   = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               load_n,
  input logic               lamp_test,
  input logic               blank,
  input logic               rb_in,
  input logic [DIGIT_W-1:0] held_q,
  input logic [SEG_N-1:0]   seg,
  input logic               rb_out
);
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    load_n |=> $stable(held_q)); // R2

  AST_ILLEGAL_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (!lamp_test && held_q > DIGIT_W'(9)) |-> seg == '0); // R4

  AST_LAMP_ALL_ON: assert property (@(posedge clk) disable iff (!rst_n)
    lamp_test |-> seg == '1); // R5

  AST_BLANK_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (blank && !lamp_test) |-> seg == '0); // R6

  AST_RIPPLE_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    rb_out |-> (rb_in && held_q == '0)); // R7

  AST_RIPPLE_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_out && !lamp_test) |-> seg == '0); // R7

  AST_OVERRIDE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && (lamp_test || blank)) |=> held_q == $past(held_q)); // R8
endmodule

bind bcd7_latch_decoder bcd7_latch_decoder_chk #(
  .DIGIT_W(DIGIT_W), .SEG_N(bcd7_pkg::SEG_N)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .load_n    (load_n),
  .lamp_test (lamp_test),
  .blank     (blank),
  .rb_in     (rb_in),
  .held_q    (held_q),
  .seg       (seg),
  .rb_out    (rb_out)
);

// File: tb/bcd7_latch_decoder_bench.sv
`timescale 1ns/1ps
module bcd7_latch_decoder_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] digit_in = '0;
  logic       load_n = 1'b1;
  logic       lamp_test = 1'b0;
  logic       blank = 1'b0;
  logic       rb_in = 1'b0;
  logic [6:0] seg;
  logic       rb_out;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;
  logic [3:0] model_digit = '0;

  typedef struct {
    logic [6:0] seg;
    logic       rbo;
    string      req;
  } exp_t;
  exp_t sb_q[$];

  always #2 clk = ~clk;

  bcd7_latch_decoder u_bcd7_latch_decoder (
    .clk(clk), .rst_n(rst_n), .digit_in(digit_in), .load_n(load_n),
    .lamp_test(lamp_test), .blank(blank), .rb_in(rb_in),
    .seg(seg), .rb_out(rb_out)
  );

  function automatic logic [6:0] glyph_of(input logic [3:0] d);
    case (d)
      4'd0: return 7'h3F; 4'd1: return 7'h06; 4'd2: return 7'h5B;
      4'd3: return 7'h4F; 4'd4: return 7'h66; 4'd5: return 7'h6D;
      4'd6: return 7'h7D; 4'd7: return 7'h07; 4'd8: return 7'h7F;
      4'd9: return 7'h6F; default: return 7'h00;
    endcase
  endfunction

  function automatic logic [6:0] expect_seg(input logic [3:0] d, input logic lt,
                                            input logic bl, input logic rbi);
    if (lt) return 7'h7F;
    if (bl) return 7'h00;
    if (rbi && d == 4'd0) return 7'h00;
    return glyph_of(d);
  endfunction

  task automatic check(input string req, input logic [6:0] s_exp, input logic r_exp);
    checks++;
    if (seg !== s_exp || rb_out !== r_exp) begin
      failures++;
      $display("FAIL %s: seg=%h rb_out=%b expected seg=%h rb_out=%b",
               req, seg, rb_out, s_exp, r_exp);
    end
  endtask

  // Driver: apply one cycle of stimulus and queue its expected result.
  task automatic drive(input logic [3:0] d, input logic ld_n, input logic lt,
                       input logic bl, input logic rbi, input string req);
    exp_t e;
    @(negedge clk);
    digit_in = d; load_n = ld_n; lamp_test = lt; blank = bl; rb_in = rbi;
    if (!ld_n) model_digit = d;
    e.seg = expect_seg(model_digit, lt, bl, rbi);
    e.rbo = rbi && (model_digit == 4'd0);
    e.req = req;
    sb_q.push_back(e);
  endtask

  // Monitor: compare just after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check(e.req, e.seg, e.rbo);
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 5000 && !done) begin
        done = 1;
        failures++;
        checks++;
        $display("FAIL watchdog: cycles=%0d expected below 5000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", 7'h3F, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after reset", 7'h3F, 1'b0);

    // R1/R3/R4: load every code.
    for (int i = 0; i < 16; i++)
      drive(4'(i), 1'b0, 1'b0, 1'b0, 1'b0, (i < 10) ? "R3 glyph" : "R4 illegal");
    // R2: hold while input moves.
    drive(4'd7, 1'b0, 1'b0, 1'b0, 1'b0, "R1 load 7");
    drive(4'd3, 1'b1, 1'b0, 1'b0, 1'b0, "R2 hold");
    drive(4'd0, 1'b1, 1'b0, 1'b0, 1'b1, "R2 hold rb");
    // R5/R6/R8 overrides.
    drive(4'd1, 1'b1, 1'b1, 1'b0, 1'b0, "R5 lamp");
    drive(4'd1, 1'b1, 1'b1, 1'b1, 1'b1, "R5 lamp over blank");
    drive(4'd1, 1'b1, 1'b0, 1'b0, 1'b0, "R8 after lamp");
    for (int i = 0; i < 6; i++)
      drive(4'd9, 1'b1, 1'b0, i[0] == 1'b0, 1'b0, "R6 blank pulse");
    drive(4'd9, 1'b1, 1'b0, 1'b0, 1'b0, "R8 after blank");
    // R7 ripple blanking.
    drive(4'd5, 1'b0, 1'b0, 1'b0, 1'b1, "R7 nonzero");
    drive(4'd0, 1'b0, 1'b0, 1'b0, 1'b1, "R7 zero");
    drive(4'd0, 1'b1, 1'b1, 1'b0, 1'b1, "R7 lamp rbo");
    drive(4'd0, 1'b1, 1'b0, 1'b1, 1'b1, "R7 blank rbo");
    drive(4'd0, 1'b1, 1'b0, 1'b0, 1'b0, "R7 rbi low");
    drive(4'd8, 1'b0, 1'b0, 1'b0, 1'b1, "R1 load 8");

    while (sb_q.size() > 0) @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule